// File: doc/BRIEF.md
# Output Vertical Frame Sequencer with Input Holdoff

This block produces the vertical timing of a display output whose frame rate sits a little below that of the video input feeding it. It counts output lines, each marked by a single-cycle line-done pulse from the horizontal timing logic. Each frame runs through a sync pulse, then the active lines, then a fixed front porch. There is no back porch: the first active line follows the last sync line at once.

Frames are grouped into cycles of eight. The last frame of a cycle does not go on to a front porch. It drops into a holdoff state and waits there for the input vertical sync, which arrives already synchronized to this clock domain. When that sync arrives, the block emits a one-cycle resync pulse, starts a new output sync, and sets the frame index back to zero. Eight output frames therefore take exactly the time of nine input frames, and the two sides are realigned once per cycle. The block comes out of reset in holdoff, so the first output frame is aligned to the input as well.

Top module: `frame_lock_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_vsync`, `line_active` and `resync` are 0 and `frame_idx` is 0; the block then sits in holdoff.
- R2: In holdoff, `line_done` has no effect on any output. A cycle with `in_vsync` high ends holdoff, and `resync` is 1 for exactly the following cycle.
- R3: `out_vsync` goes high in the cycle after holdoff ends or after the last porch line. It stays high for exactly SYNC_LINES (default 4) line-done pulses.
- R4: After the last sync line, `line_active` is 1 at once, with no back-porch line in between. It stays 1 for exactly ACTIVE_LINES line-done pulses.
- R5: In frames with index 0 to FRAMES-2, the active lines are followed by PORCH_LINES (default 8) lines in which both `out_vsync` and `line_active` are 0.
- R6: `frame_idx` is 0 in the frame that starts when holdoff ends. It goes up by one each time a porch hands over to a new sync.
- R7: After the active lines of frame FRAMES-1 (default 7), the block enters holdoff with no porch. Both outputs stay 0 and `frame_idx` holds FRAMES-1 until `in_vsync` arrives.
- R8: `in_vsync` has no effect outside holdoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_done | input | 1 | One-cycle pulse at the end of each output line |
| in_vsync | input | 1 | Input-side vertical sync, already synchronized to `clk` |
| out_vsync | output | 1 | Output vertical sync, high during the sync lines |
| line_active | output | 1 | High during the active lines of a frame |
| frame_idx | output | FW | Index of the current output frame within the cycle |
| resync | output | 1 | One-cycle pulse when holdoff ends |

## Verification
The bench targets the handover points that are easy to get wrong:
- **Sync to active.** A design that inserted a back-porch line would be caught because the first active line would arrive one pulse late.
- **Last frame.** A design that ran the porch on the eighth frame would show eight extra blank lines before holdoff. A design that skipped holdoff would start a ninth sync on its own.
- **Holdoff.** Line-done pulses are sent during holdoff, and an input sync is sent in the middle of an active line. A design that reacted to either would move the sync early or shift every line that follows.
- **Resync.** The bench checks that the resync pulse lasts one cycle, that the frame index returns to zero, and that the index counts up correctly over two full cycles.

// File: rtl/fls_pkg.sv
package fls_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SYNC   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_PORCH  = 2'd3
  } vphase_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fls_line_ctr.sv
module fls_line_ctr #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          seg_last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign seg_last = step && (cnt_q == (limit - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (seg_last) cnt_d = '0;
      else          cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fls_frame_ctr.sv
module fls_frame_ctr #(
  parameter int FRAMES = 8,
  parameter int FW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [FW-1:0] idx,
  output logic          is_final
);

  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FW-1:0] idx_q;
  logic [FW-1:0] idx_d;
  logic          upd;

  assign is_final = (idx_q == LAST);
  assign upd      = inc || clr;

  always_comb begin
    idx_d = idx_q;
    if (clr)           idx_d = '0;
    else if (is_final) idx_d = '0;
    else               idx_d = idx_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (upd) idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/fls_fsm.sv
module fls_fsm
  import fls_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_done,
  input  logic    in_vsync,
  input  logic    seg_last,
  input  logic    frame_final,
  output vphase_t phase,
  output logic    step,
  output logic    frame_inc,
  output logic    frame_clr,
  output logic    resync_pulse
);

  vphase_t ph_q;
  vphase_t ph_d;
  logic    resync_q;
  logic    release_hold;

  assign release_hold = (ph_q == ST_HOLD) && in_vsync;
  assign step         = line_done && (ph_q != ST_HOLD);
  assign frame_inc    = (ph_q == ST_PORCH) && seg_last;
  assign frame_clr    = release_hold;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      ST_HOLD:   if (in_vsync) ph_d = ST_SYNC;
      ST_SYNC:   if (seg_last) ph_d = ST_ACTIVE;
      ST_ACTIVE: if (seg_last) ph_d = frame_final ? ST_HOLD : ST_PORCH;
      ST_PORCH:  if (seg_last) ph_d = ST_SYNC;
      default:   ph_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= ST_HOLD;
      resync_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      resync_q <= release_hold;
    end
  end

  assign phase        = ph_q;
  assign resync_pulse = resync_q;

endmodule

// File: rtl/frame_lock_seq.sv
module frame_lock_seq
  import fls_pkg::*;
#(
  parameter int ACTIVE_LINES = 480,
  parameter int PORCH_LINES  = 8,
  parameter int SYNC_LINES   = 4,
  parameter int FRAMES       = 8,
  parameter int FW           = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_done,
  input  logic          in_vsync,
  output logic          out_vsync,
  output logic          line_active,
  output logic [FW-1:0] frame_idx,
  output logic          resync
);

  localparam int MAXL = max3(ACTIVE_LINES, PORCH_LINES, SYNC_LINES);
  localparam int CW   = $clog2(MAXL + 1);

  vphase_t       phase;
  logic          step;
  logic          seg_last;
  logic          frame_inc;
  logic          frame_clr;
  logic          frame_final;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (phase)
      ST_ACTIVE: limit = CW'(ACTIVE_LINES);
      ST_PORCH:  limit = CW'(PORCH_LINES);
      default:   limit = CW'(SYNC_LINES);
    endcase
  end

  fls_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_done    (line_done),
    .in_vsync     (in_vsync),
    .seg_last     (seg_last),
    .frame_final  (frame_final),
    .phase        (phase),
    .step         (step),
    .frame_inc    (frame_inc),
    .frame_clr    (frame_clr),
    .resync_pulse (resync)
  );

  fls_line_ctr #(.CW(CW)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .limit    (limit),
    .seg_last (seg_last)
  );

  fls_frame_ctr #(.FRAMES(FRAMES), .FW(FW)) u_frames (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (frame_inc),
    .clr      (frame_clr),
    .idx      (frame_idx),
    .is_final (frame_final)
  );

  assign out_vsync   = (phase == ST_SYNC);
  assign line_active = (phase == ST_ACTIVE);

endmodule

// File: rtl/fls_checker.sv
module fls_checker #(
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_vsync,
  input logic          line_active,
  input logic [FW-1:0] frame_idx,
  input logic          resync
);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vsync && line_active));

  // R2
  resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  // R3
  resync_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> out_vsync);

  // R6
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (frame_idx == '0));

  // R6
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_vsync) && !resync) |-> (frame_idx == $past(frame_idx) + FW'(1)));

  // R4
  no_back_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vsync) |-> line_active);

endmodule

bind frame_lock_seq fls_checker #(.FW(FW)) u_fls_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_vsync   (out_vsync),
  .line_active (line_active),
  .frame_idx   (frame_idx),
  .resync      (resync)
);

// File: tb/frame_lock_seq_test.sv
`timescale 1ns/1ps
module frame_lock_seq_test;

  localparam int ACT = 5;
  localparam int PCH = 8;
  localparam int SYN = 4;
  localparam int NFR = 8;
  localparam int FW  = 3;

  typedef struct {
    logic          v;
    logic          a;
    logic [FW-1:0] f;
    string         req;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          line_done;
  logic          in_vsync;
  logic          out_vsync;
  logic          line_active;
  logic [FW-1:0] frame_idx;
  logic          resync;

  int   total;
  int   bad;
  exp_t exp_q[$];

  frame_lock_seq #(
    .ACTIVE_LINES(ACT), .PORCH_LINES(PCH), .SYNC_LINES(SYN), .FRAMES(NFR), .FW(FW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .in_vsync(in_vsync),
    .out_vsync(out_vsync), .line_active(line_active), .frame_idx(frame_idx),
    .resync(resync)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each line's outputs just after the negedge that raises line_done
  always @(negedge clk) begin
    #1;
    if (rst_n && line_done) begin
      if (exp_q.size() == 0) begin
        check("R7", "unexpected line", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "out_vsync",   int'(out_vsync),   int'(e.v));
        check(e.req, "line_active", int'(line_active), int'(e.a));
        check(e.req, "frame_idx",   int'(frame_idx),   int'(e.f));
      end
    end
  end

  // driver: queue the expectation, then deliver one line pulse
  task automatic send_line(input logic v, input logic a, input int f,
                           input string req, input logic vs_in);
    exp_t e;
    e.v = v; e.a = a; e.f = FW'(f); e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    line_done = 1'b1;
    in_vsync  = vs_in;
    @(negedge clk);
    line_done = 1'b0;
    in_vsync  = 1'b0;
  endtask

  task automatic release_hold();
    @(negedge clk);
    in_vsync = 1'b1;
    @(negedge clk);
    in_vsync = 1'b0;
    #1;
    check("R2", "resync high", int'(resync), 1);
    check("R3", "sync starts", int'(out_vsync), 1);
    check("R6", "frame wraps", int'(frame_idx), 0);
    @(negedge clk);
    #1;
    check("R2", "resync one cycle", int'(resync), 0);
  endtask

  task automatic run_cycle(input bit poke);
    for (int f = 0; f < NFR; f++) begin
      for (int s = 0; s < SYN; s++) send_line(1'b1, 1'b0, f, "R3", 1'b0);
      for (int a = 0; a < ACT; a++)
        send_line(1'b0, 1'b1, f, (poke && f == 2) ? "R8" : "R4", poke && f == 2 && a == 1);
      if (f < NFR - 1)
        for (int p = 0; p < PCH; p++) send_line(1'b0, 1'b0, f, "R5", 1'b0);
    end
  endtask

  bit finished;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; line_done = 1'b0; in_vsync = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "vsync in reset",  int'(out_vsync), 0);
    check("R1", "resync in reset", int'(resync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "out_vsync",   int'(out_vsync), 0);
    check("R1", "line_active", int'(line_active), 0);
    check("R1", "frame_idx",   int'(frame_idx), 0);
    check("R1", "resync",      int'(resync), 0);

    // R2: line pulses in holdoff change nothing
    for (int i = 0; i < 3; i++) send_line(1'b0, 1'b0, 0, "R2", 1'b0);
    release_hold();
    // R8: input sync injected mid active line of frame 2
    run_cycle(1'b1);
    // R7: holdoff after the last frame, no porch, index held
    for (int i = 0; i < 4; i++) send_line(1'b0, 1'b0, NFR - 1, "R7", 1'b0);
    release_hold();
    run_cycle(1'b0);
    for (int i = 0; i < 2; i++) send_line(1'b0, 1'b0, NFR - 1, "R7", 1'b0);
    repeat (2) @(negedge clk);
    #2;
    check("R7", "scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule